// File: doc/BRIEF.md
# Byte-Addressed Register File on a Two-Wire Serial Slave

This block is an I2C slave. It answers one 7-bit device address, 0x69 by default, and gives the bus master read and write access to a 256-entry byte register file. The master first sends the device address with the direction bit in the least significant position. A write then carries a register index, followed by any number of data bytes. A read returns bytes starting at the current pointer. The pointer advances after every byte that is stored or sent, and it keeps its value between transactions. A read with no index given therefore continues from one past the last byte touched.

The block samples SCL and SDA with a faster system clock through a two-stage synchroniser and finds the bus edges and conditions from the sampled values. It never drives SDA high. Its only output is an enable that pulls the shared line low, so it fits an open-drain pad. The block does not stretch the clock, and it does not handle 10-bit or general-call addressing.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), the pointer is 0, and register i holds i XOR `DFLT_XOR` (0x5A by default).
- R2: When the first byte after a START carries a 7-bit address other than `DEV_ADDR`, the block does not acknowledge it. It then stays off the bus and stores nothing until the next START.
- R3: A write frame is the address byte with bit0=0, an index byte, then data bytes. The block acknowledges each byte by holding SDA low through the ninth SCL pulse, and it stores each data byte at the pointer.
- R4: Each data byte written advances the pointer by one, so consecutive bytes land at consecutive indices.
- R5: The pointer wraps from 0xFF to 0x00 during both writes and reads.
- R6: A read with no index given (address byte with bit0=1 directly after START) returns the byte one past the last byte written or read, even when that access was in an earlier transaction.
- R7: A write that carries only an index sets the pointer. A repeated START followed by a read then returns bytes from that index.
- R8: During a read, the block sends each byte MSB first. A master ACK (SDA low on the ninth pulse) fetches the next byte. A master NACK ends the transfer with SDA released and no further byte consumed.
- R9: The block never pulls SDA low while SCL is high during a bit that the master owns, meaning address, index, write data, or the master's acknowledge.
- R10: A START restarts address reception from any state. A STOP returns the block to idle with SDA released and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A pointer that is off by one, or that fails to persist or wrap, appears at the data byte of the next read. That is at most one frame after the write that disturbed it, so every read is compared against a behavioural copy of the register file and pointer. A wrong bus state shows up as a missing or spurious acknowledge on the ninth pulse of the affected byte. Releasing SDA at the wrong time shows up within the same SCL high phase. This is checked on every system clock while the master owns the line.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] DFLT_XOR = 8'h5A,
  parameter int         AW       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_IDX, S_IDXACK, S_WR, S_WRACK, S_RD, S_MACK
  } state_t;

  state_t          state;
  logic [2:0]      scl_q, sda_q;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [AW-1:0]   ptr;
  logic            rw;
  logic [7:0]      mem [DEPTH];

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_hi   = scl_q[1] & scl_q[2];
  wire start    = scl_hi & ~sda_q[1] & sda_q[2];
  wire stop     = scl_hi & sda_q[1] & ~sda_q[2];
  wire byte_in  = scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ DFLT_XOR;
    end else if (start) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_IDX, S_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_in) begin
            bitcnt <= '0;
            case (state)
              S_DEV: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_DEVACK;
                end else begin
                  state  <= S_IDLE;
                end
              end
              S_IDX: begin
                ptr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
                state  <= S_IDXACK;
              end
              default: begin
                mem[ptr] <= shreg;
                ptr      <= ptr + AW'(1);
                sda_oe   <= 1'b1;
                state    <= S_WRACK;
              end
            endcase
          end
        end
        S_DEVACK, S_IDXACK, S_WRACK: begin
          if (scl_fall) begin
            if (state == S_DEVACK && rw) begin
              shreg  <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              ptr    <= ptr + AW'(1);
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= (state == S_DEVACK) ? S_IDX : S_WR;
            end
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= S_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_q[1]) state <= S_IDLE;
          end else if (scl_fall) begin
            shreg  <= mem[ptr];
            sda_oe <= ~mem[ptr][7];
            ptr    <= ptr + AW'(1);
            state  <= S_RD;
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_DEV && !sda_oe));

  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_oe));

  a_r2_foreign_addr_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && byte_in && shreg[7:1] != DEV_ADDR && !start && !stop)
      |=> (state == S_IDLE && !sda_oe));

  a_r5_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '1 && state == S_WR && byte_in && !start && !stop) |=> (ptr == '0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  a_r8_master_ack_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK) |-> !sda_oe);
endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  localparam int Q = 8;
  localparam logic [7:0] XORV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic owns = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [256];
  int ref_ptr = 0;

  always #5 clk = ~clk;

  i2c_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R9: slave must stay off SDA while the master owns a bit
  always @(negedge clk) if (rst_n && owns) chk(!sda_oe, "R9", int'(sda_oe), 0);

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    waitq(Q); sda_m = 1'b0;
    waitq(Q); scl_m = 1'b1;
    waitq(Q); sda_m = 1'b1;
    waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      waitq(Q); sda_m = b[i];
      waitq(Q); scl_m = 1'b1; owns = 1'b1;
      waitq(2*Q); owns = 1'b0; scl_m = 1'b0;
    end
    waitq(Q); sda_m = 1'b1;
    waitq(Q); scl_m = 1'b1;
    waitq(Q); acked = (sda_line == 1'b0);
    waitq(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    waitq(Q); sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (i != 7) waitq(Q);
      waitq(Q); scl_m = 1'b1;
      waitq(Q); b[i] = sda_line;
      waitq(Q); scl_m = 1'b0;
    end
    waitq(Q); sda_m = ~give_ack;
    waitq(Q); scl_m = 1'b1; owns = 1'b1;
    waitq(2*Q); owns = 1'b0; scl_m = 1'b0;
  endtask

  task automatic expect_ack(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    chk(a, req, int'(a), 1);
  endtask

  task automatic write_burst(input logic [7:0] idx, input int n, input logic [7:0] seed, input string req);
    bus_start();
    expect_ack(8'hD2, req);
    expect_ack(idx, req);
    ref_ptr = idx;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 7);
      expect_ack(d, req);
      ref_mem[ref_ptr] = d;
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic read_from_ptr(input int n, input string req);
    logic [7:0] got;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      chk(got == ref_mem[ref_ptr], req, got, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
    chk(!sda_oe, "R8", int'(sda_oe), 0);
  endtask

  task automatic read_current(input int n, input string req);
    bus_start();
    expect_ack(8'hD3, req);
    read_from_ptr(n, req);
  endtask

  task automatic read_random(input logic [7:0] idx, input int n, input string req);
    bus_start();
    expect_ack(8'hD2, req);
    expect_ack(idx, req);
    ref_ptr = idx;
    bus_start();
    expect_ack(8'hD3, req);
    read_from_ptr(n, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ XORV;
    waitq(4);
    chk(!sda_oe, "R1", int'(sda_oe), 0);
    rst_n = 1'b1;
    waitq(4);
    chk(!sda_oe, "R1", int'(sda_oe), 0);

    read_current(2, "R1");
    write_burst(8'h10, 1, 8'h3C, "R3");
    write_burst(8'h20, 4, 8'h81, "R4");
    write_burst(8'hFE, 3, 8'hC4, "R5");
    read_random(8'h20, 4, "R7");
    read_current(1, "R6");
    read_random(8'hFE, 3, "R5");
    read_current(3, "R8");

    begin
      bit a;
      bus_start();
      send_byte(8'hD0, a); chk(!a, "R2", int'(a), 0);
      send_byte(8'h10, a); chk(!a, "R2", int'(a), 0);
      send_byte(8'hEE, a); chk(!a, "R2", int'(a), 0);
      bus_stop();
    end
    read_current(1, "R2");
    read_random(8'h10, 1, "R2");

    bus_start();
    expect_ack(8'hD2, "R10");
    expect_ack(8'h30, "R10");
    ref_ptr = 8'h30;
    bus_stop();
    read_current(2, "R10");

    bus_start();
    expect_ack(8'hD2, "R10");
    bus_start();
    expect_ack(8'hD3, "R10");
    read_from_ptr(1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule